// File: doc/BRIEF.md
# Deglitched Two-Input Interrupt Merger

This block takes two active-low interrupt request lines from separate downstream segments and merges them into a single interrupt output. The output is meant to drive an open-drain pin low. Each line is first brought into the system clock domain. It then passes a level filter that rejects short pulses. The window for rejecting a pulse depends on its direction: a dip towards the asserted (low) level must last longer than a bump back towards the idle (high) level before it is believed. The filtered state of every line is also offered as a status bit, for a register block to read.

Channel selection has no influence here. A request on a segment is reported whether or not that segment is currently connected. With active-low lines, the merge is a wired AND: the pin is pulled low while any filtered line is low. The filter windows are derived from one parameter, the number of system clock cycles in one microsecond.

Top module: `irq_merge_filter`

## Requirements
- R1: While `rst_n` is low, and afterwards until an input has been accepted as low, every `irq_stat` bit is 0 and `irq_pull_lo` is 0.
- R2: Inputs are active low. `irq_stat[i]` = 1 means input i is filtered as low (request pending). `irq_pull_lo` = 1 means the open-drain pin is driven low.
- R3: `irq_pull_lo` becomes 1 one clock after any `irq_stat` bit is 1, whichever input it is.
- R4: A raw low level seen on fewer than LOW_CYC = CYC_PER_US consecutive clock samples is ignored. It changes neither its status bit nor the output. A low level held for LOW_CYC samples is accepted.
- R5: A raw high level seen on fewer than HIGH_CYC = CYC_PER_US/2 consecutive samples (minimum 1) while the input is filtered low is ignored. It does not release a held request. HIGH_CYC samples are accepted.
- R6: Each raw input is sampled through two flops. When the input is accepted, its status bit changes at the clock edge N+1 edges after the first sample of the new level, where N is the window that applies. `irq_pull_lo` follows one edge later. At the default parameter this is within 4 µs for assertion and within 2 µs for release.
- R7: `irq_pull_lo` returns to 0 one clock after all `irq_stat` bits are 0.
- R8: Both inputs may be pending at once. Each status bit follows only its own input.
- R9: Applying `rst_n` while a request is held clears the status and the output at once. A request still present afterwards is accepted again only after its full low window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_raw_n | input | NUM_IN | Raw active-low interrupt requests, asynchronous to clk |
| irq_stat | output | NUM_IN | Filtered status, 1 = request pending on that input |
| irq_pull_lo | output | 1 | Registered enable that drives the shared interrupt pin low |

## Verification
The bench builds the block with NUM_IN = 2 and CYC_PER_US = 8. This gives a low window of 8 samples and a high window of 4, so pulses one sample shorter than, and exactly equal to, each window fit in a few dozen cycles. Random hold lengths from 1 to 12 cycles then straddle both windows over and over, on each input independently and on both together. A reset is also applied while a request is held. Every cycle, both status bits and the pin enable are compared with a cycle-exact model that the bench derives from the sampling and window rules.

// File: rtl/irqm_pkg.sv
// Shared helpers for the interrupt merger.
// Assumes: callers pass positive cycle counts.
package irqm_pkg;

    // Filtered line level, named for readability.
    typedef enum logic {
        LINE_LOW  = 1'b0,
        LINE_HIGH = 1'b1
    } line_lvl_e;

    // Width needed to count from 0 up to n-1 (at least 1 bit).
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    // Larger of two cycle counts.
    function automatic int unsigned max_cyc(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/irqm_sync2.sv
// Two-flop synchronizer for one asynchronous level.
// Assumes: the input is a slow level; no pulse-width guarantee is needed here.
// Reset loads RST_VAL into both stages.
module irqm_sync2 #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic stage1_q;
    logic stage2_q;

    // Shift the raw level through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= RST_VAL;
            stage2_q <= RST_VAL;
        end else begin
            stage1_q <= d_async;
            stage2_q <= stage1_q;
        end
    end

    assign q_sync = stage2_q;

endmodule

// File: rtl/irqm_deglitch.sv
// Asymmetric level filter. The filtered level moves to the synchronized
// level only after that level has differed from it for a run of cycles:
// FALL_CYC cycles to go low, RISE_CYC cycles to go high.
// Any sample equal to the current filtered level restarts the run.
// Assumes: the input is already synchronous to clk; FALL_CYC, RISE_CYC >= 1.
module irqm_deglitch
    import irqm_pkg::*;
#(
    parameter int unsigned FALL_CYC = 8,
    parameter int unsigned RISE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic s_in,
    output logic lvl_o
);

    localparam int unsigned MAXC = max_cyc(FALL_CYC, RISE_CYC);
    localparam int unsigned CW   = cnt_width(MAXC);
    localparam logic [CW-1:0] FALL_LAST = CW'(FALL_CYC - 1);
    localparam logic [CW-1:0] RISE_LAST = CW'(RISE_CYC - 1);

    line_lvl_e     lvl_q;
    logic [CW-1:0] run_q;
    logic [CW-1:0] last_c;
    logic          differ_c;
    logic          flip_c;

    // Choose the window for the pending direction; detect its completion.
    always_comb begin
        last_c   = (lvl_q == LINE_HIGH) ? FALL_LAST : RISE_LAST;
        differ_c = (s_in != logic'(lvl_q));
        flip_c   = differ_c && (run_q == last_c);
    end

    // Count the disagreeing run and flip the level when it completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= LINE_HIGH;
            run_q <= '0;
        end else if (!differ_c) begin
            run_q <= '0;
        end else if (flip_c) begin
            lvl_q <= (lvl_q == LINE_HIGH) ? LINE_LOW : LINE_HIGH;
            run_q <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    assign lvl_o = logic'(lvl_q);

    // R4: a fall is only ever toward a low synchronized sample.
    p_fall_toward_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lvl_o) |-> !$past(s_in));

    // R5: a rise is only ever toward a high synchronized sample.
    p_rise_toward_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lvl_o) |-> $past(s_in));

    // R6: agreement between input and level holds the level.
    p_hold_when_equal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_in == lvl_o) |=> $stable(lvl_o));

    // R4: the run counter never passes the longer window.
    p_run_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(run_q) < int'(MAXC)));

endmodule

// File: rtl/irq_merge_filter.sv
// Merges NUM_IN active-low interrupt lines into one open-drain pull-low
// enable, after synchronizing and deglitching each line. Low pulses need
// CYC_PER_US samples to count; high gaps need CYC_PER_US/2 samples.
// Assumes: CYC_PER_US >= 2 so that both latency bounds are met.
module irq_merge_filter #(
    parameter int unsigned NUM_IN     = 2,
    parameter int unsigned CYC_PER_US = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] irq_raw_n,
    output logic [NUM_IN-1:0] irq_stat,
    output logic              irq_pull_lo
);

    localparam int unsigned LOW_CYC  = (CYC_PER_US < 1) ? 1 : CYC_PER_US;
    localparam int unsigned HIGH_CYC = (CYC_PER_US / 2 < 1) ? 1 : CYC_PER_US / 2;

    logic [NUM_IN-1:0] sync_n;
    logic [NUM_IN-1:0] filt_n;
    logic              pull_q;

    for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_line
        irqm_sync2 #(
            .RST_VAL (1'b1)
        ) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .d_async (irq_raw_n[gi]),
            .q_sync  (sync_n[gi])
        );

        irqm_deglitch #(
            .FALL_CYC (LOW_CYC),
            .RISE_CYC (HIGH_CYC)
        ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .s_in  (sync_n[gi]),
            .lvl_o (filt_n[gi])
        );
    end

    assign irq_stat = ~filt_n;

    // Register the wired-AND result so the pin enable cannot glitch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pull_q <= 1'b0;
        end else begin
            pull_q <= ~(&filt_n);
        end
    end

    assign irq_pull_lo = pull_q;

    // R3: any pending status drives the pin on the next cycle.
    p_pending_pulls_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_stat) |=> irq_pull_lo);

    // R7: no pending status releases the pin on the next cycle.
    p_idle_releases_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(|irq_stat) |=> !irq_pull_lo);

    // R3: the pin never starts pulling without a pending status.
    p_rise_has_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pull_lo) |-> $past(|irq_stat));

endmodule

// File: tb/irq_merge_filter_bench.sv
module irq_merge_filter_bench;

    localparam int NI  = 2;
    localparam int CPU = 8;
    localparam int LOW_W  = CPU;
    localparam int HIGH_W = (CPU / 2 < 1) ? 1 : CPU / 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NI-1:0] raw_n;
    logic [NI-1:0] stat;
    logic          pull_lo;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    irq_merge_filter #(.NUM_IN(NI), .CYC_PER_US(CPU)) u_irq_merge_filter (
        .clk(clk), .rst_n(rst_n), .irq_raw_n(raw_n),
        .irq_stat(stat), .irq_pull_lo(pull_lo)
    );

    // Model state: two sample stages, filtered level, run, pin.
    logic [NI-1:0] m_q1, m_q2, m_lvl;
    int            m_run [NI];
    logic          m_pin;
    bit            armed = 1'b0;

    // Window that applies when the filtered level is `lvl` (R4, R5).
    function automatic int win_for(input logic lvl);
        return lvl ? LOW_W : HIGH_W;
    endfunction

    task automatic check(input string tag);
        checks++;
        if (stat !== ~m_lvl) begin
            fails++;
            $display("FAIL %s irq_stat actual=%b expected=%b t=%0t", tag, stat, ~m_lvl, $time);
        end
        checks++;
        if (pull_lo !== m_pin) begin
            fails++;
            $display("FAIL %s irq_pull_lo actual=%b expected=%b t=%0t", tag, pull_lo, m_pin, $time);
        end
    endtask

    // Advance the model by the edge that will sample current inputs.
    task automatic model_edge();
        logic [NI-1:0] old_lvl;
        old_lvl = m_lvl;
        if (!rst_n) begin
            m_q1 = '1; m_q2 = '1; m_lvl = '1; m_pin = 1'b0;
            for (int i = 0; i < NI; i++) m_run[i] = 0;
        end else begin
            m_pin = ~(&old_lvl);
            for (int i = 0; i < NI; i++) begin
                if (m_q2[i] == old_lvl[i]) m_run[i] = 0;
                else if (m_run[i] == win_for(old_lvl[i]) - 1) begin
                    m_lvl[i] = ~old_lvl[i];
                    m_run[i] = 0;
                end else m_run[i] = m_run[i] + 1;
            end
            m_q2 = m_q1;
            m_q1 = raw_n;
        end
    endtask

    // One cycle: compare after the last edge, drive, then model next edge.
    task automatic step(input string tag, input logic rs, input logic [NI-1:0] r);
        @(negedge clk);
        if (armed) check(tag);
        rst_n = rs;
        raw_n = r;
        model_edge();
        armed = 1'b1;
    endtask

    task automatic hold(input string tag, input logic [NI-1:0] r, input int n);
        for (int k = 0; k < n; k++) step(tag, 1'b1, r);
    endtask

    initial begin
        #(10 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int rem [NI];
        logic [NI-1:0] cur;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; raw_n = '1;
        m_q1 = '1; m_q2 = '1; m_lvl = '1; m_pin = 1'b0;
        for (int i = 0; i < NI; i++) m_run[i] = 0;
        // R1: reset state, including a low raw input during reset.
        for (int k = 0; k < 4; k++) step("R1", 1'b0, 2'b00);
        hold("R1", 2'b11, 12);
        // R4: low pulse one short of the window is ignored, then exact window.
        hold("R4", 2'b10, LOW_W - 1);
        hold("R4", 2'b11, 12);
        hold("R4,R6", 2'b10, LOW_W);
        hold("R6,R3", 2'b10, 4);
        // R5: high gap one short of the window keeps the request held.
        hold("R5", 2'b11, HIGH_W - 1);
        hold("R5", 2'b10, 6);
        hold("R5,R7", 2'b11, HIGH_W + 4);
        // R8: both inputs, independent release.
        hold("R8", 2'b00, LOW_W + 4);
        hold("R8", 2'b01, HIGH_W + 4);
        hold("R8,R7", 2'b11, HIGH_W + 4);
        // R9: reset during a held request, then re-acceptance.
        hold("R9", 2'b01, LOW_W + 4);
        for (int k = 0; k < 2; k++) step("R9", 1'b0, 2'b01);
        hold("R9", 2'b01, LOW_W + 5);
        hold("R9", 2'b11, HIGH_W + 4);
        // R2: random hold lengths straddling both windows.
        cur = 2'b11;
        for (int i = 0; i < NI; i++) rem[i] = 1;
        for (int k = 0; k < 20000; k++) begin
            for (int i = 0; i < NI; i++) begin
                rem[i]--;
                if (rem[i] == 0) begin
                    cur[i] = ~cur[i];
                    rem[i] = $urandom_range(1, 12);
                end
            end
            step("R2,R3,R6", 1'b1, cur);
        end
        hold("R7", 2'b11, 20);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule